// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block turns single word requests from a synchronous host into the strobe sequences of an asynchronous, multiplexed-address DRAM with a 16-bit data word and an 18-bit word address. Each access opens a row by driving the row half of the address and dropping the row strobe. It then switches the bus to the column half and pulses the column strobes. Writes pulse only the byte lanes that are enabled. Reads enable the memory's output and capture the word at the end of the column pulse.

After an access the row is left open. A following request to the same row is served as a fast page column access, with no new row strobe. A request to another row closes the open row, precharges and reopens. A pending refresh request also closes the row, and so does the row-open time nearing its upper bound. Every timing minimum is given in nanoseconds and rounded up to whole clock cycles.

The host raises `req` with its fields and keeps them stable until `done` pulses. In the cycle `done` is high, the host presents its next request or drops `req`.

Top module: `dram_page_seq`

## Requirements
- R1: While reset is held, and afterwards with no request, `ras_n`, `cas_hi_n`, `cas_lo_n`, `we_n` and `oe_n` are high, and `dq_oe` and `done` are low.
- R2: The row address `req_addr[17:9]` is on `mem_addr` when `ras_n` falls. The column address `req_addr[8:0]` is on `mem_addr` when the column strobes fall.
- R3: The row address is held for at least the row-hold time after `ras_n` falls. The column strobes fall no earlier than the RAS-to-CAS delay after `ras_n` falls, and only while `ras_n` is low.
- R4: `cas_hi_n` gates data bits 15:8 and `cas_lo_n` gates bits 7:0. A write pulses `cas_hi_n` only if `req_be[1]` is set and `cas_lo_n` only if `req_be[0]` is set. A read pulses both.
- R5: During a write column pulse, `we_n` is low, `oe_n` is high and `dq_oe` is high with the write data on `dq_out`. `mem_addr` and `we_n` stay stable while a column strobe is low.
- R6: A read drives `oe_n` low during the column pulse. It samples `dq_in` at the end of that pulse, which is at least the CAS access time after the column strobe fell and at least the RAS access time after `ras_n` fell. `done` is a one-cycle pulse, and for a read `rd_data` holds the word in that cycle.
- R7: A request to the row that is open, with `refresh_pend` low, is served with `ras_n` held low. The column strobes stay high for at least the CAS precharge time between columns.
- R8: A request to a different row, or `refresh_pend` high, makes `ras_n` rise before any further access. With `refresh_pend` high, the row also closes when no request is waiting.
- R9: `ras_n` stays high for at least the precharge time before it falls again. Successive falls of `ras_n` are at least the random cycle time apart.
- R10: `ras_n` is never low for more than the maximum RAS-low time. An open row closes on its own before that limit, even in the middle of a burst.
- R11: `dq_oe` and a low `oe_n` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, held until `done` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address: row in bits 17:9, column in bits 8:0 |
| req_be | input | 2 | Write byte enables: bit 1 = data 15:8, bit 0 = data 7:0 |
| req_wdata | input | 16 | Write data |
| refresh_pend | input | 1 | A refresh is waiting; close the open row |
| rd_data | output | 16 | Read data, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| ras_n | output | 1 | Row strobe, active low |
| cas_hi_n | output | 1 | Upper byte column strobe, active low |
| cas_lo_n | output | 1 | Lower byte column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 9 | Multiplexed row/column address |
| dq_out | output | 16 | Data driven toward the memory |
| dq_oe | output | 1 | Enable for the controller's data drivers |
| dq_in | input | 16 | Data returned by the memory |

## Verification
The bench drives the block against a memory model that latches the row and column from the strobes. The model returns junk in the first cycle of a column pulse, so a read sampled too early shows up as wrong data.

The first pattern is isolated accesses separated by refresh closes. These tell a correct address split from swapped or shifted halves. The second pattern is partial-byte writes to one word, which tell each lane strobe apart from the other. The third is same-row sequences and alternating-row sequences. Counting row strobe falls in these separates a page hit from a needless reopen or a missed close. Last, a long idle open row and a long same-row burst show whether the row-open bound forces a close and whether the waiting request is still completed afterwards.

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
  parameter int MAW          = 9,
  parameter int DW           = 16,
  parameter int CLK_NS       = 10,
  parameter int T_RAH_NS     = 5,
  parameter int T_RCD_NS     = 20,
  parameter int T_CAS_NS     = 15,
  parameter int T_CAC_NS     = 10,
  parameter int T_RAC_NS     = 30,
  parameter int T_CP_NS      = 5,
  parameter int T_RP_NS      = 25,
  parameter int T_RC_NS      = 70,
  parameter int T_RAS_MAX_NS = 75000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [2*MAW-1:0]  req_addr,
  input  logic [1:0]        req_be,
  input  logic [DW-1:0]     req_wdata,
  input  logic              refresh_pend,
  output logic [DW-1:0]     rd_data,
  output logic              done,
  output logic              ras_n,
  output logic              cas_hi_n,
  output logic              cas_lo_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [MAW-1:0]    mem_addr,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  input  logic [DW-1:0]     dq_in
);
  localparam int AW = 2 * MAW;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RAH_C   = cyc(T_RAH_NS);
  localparam int RCD_C   = cyc(T_RCD_NS);
  localparam int CASW_C  = cyc(T_CAS_NS);
  localparam int CAC_C   = cyc(T_CAC_NS);
  localparam int COL_C   = (CASW_C > CAC_C) ? CASW_C : CAC_C;
  localparam int RAC_C   = cyc(T_RAC_NS);
  localparam int CP_C    = cyc(T_CP_NS);
  localparam int RP_C    = cyc(T_RP_NS);
  localparam int RC_C    = cyc(T_RC_NS);
  localparam int RMAX_C  = cyc(T_RAS_MAX_NS);
  localparam int LIMIT_C = RMAX_C - COL_C - 3;
  localparam int TM1     = (RAH_C > COL_C) ? RAH_C : COL_C;
  localparam int TM2     = (CP_C > RP_C) ? CP_C : RP_C;
  localparam int TMAX    = (TM1 > TM2) ? TM1 : TM2;
  localparam int TW      = $clog2(TMAX + 1) + 1;
  localparam int RW      = $clog2(RMAX_C + RC_C + 2) + 1;

  localparam logic [TW-1:0] RAH_T = TW'(RAH_C - 1);
  localparam logic [TW-1:0] COL_T = TW'(COL_C - 1);
  localparam logic [TW-1:0] CP_T  = TW'((CP_C > 1) ? CP_C - 2 : 0);
  localparam logic [TW-1:0] RP_T  = TW'(RP_C - 1);
  localparam logic [RW-1:0] RCD_R = RW'(RCD_C - 1);
  localparam logic [RW-1:0] RAC_R = RW'(RAC_C - 1);
  localparam logic [RW-1:0] RC_R  = RW'(RC_C - 1);
  localparam logic [RW-1:0] LIM_R = RW'(LIMIT_C);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COLA, S_CAS, S_OPEN, S_PRE} st_t;

  st_t            st, nxt;
  logic [TW-1:0]  t;
  logic [RW-1:0]  rc;
  logic [AW-1:0]  a_r;
  logic           we_r;
  logic [1:0]     be_r;
  logic [DW-1:0]  wd_r;
  logic           hit, load, fin, strobe;

  assign hit    = req_addr[AW-1:MAW] == a_r[AW-1:MAW];
  assign strobe = st == S_CAS;
  assign fin    = strobe && (nxt == S_OPEN);
  assign load   = (st == S_IDLE && req) || (st == S_OPEN && nxt == S_COLA);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (req) nxt = S_ROW;
      S_ROW:  if (t >= RAH_T) nxt = S_COLA;
      S_COLA: if (rc >= RCD_R) nxt = S_CAS;
      S_CAS:  if (t >= COL_T && rc >= RAC_R) nxt = S_OPEN;
      S_OPEN: begin
        if (refresh_pend || rc >= LIM_R) nxt = S_PRE;
        else if (req && !hit)            nxt = S_PRE;
        else if (req && t >= CP_T)       nxt = S_COLA;
      end
      S_PRE:  if (t >= RP_T && rc >= RC_R) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      t       <= '0;
      rc      <= '0;
      a_r     <= '0;
      we_r    <= 1'b0;
      be_r    <= '0;
      wd_r    <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      st   <= nxt;
      t    <= (nxt != st) ? '0 : ((&t) ? t : t + 1'b1);
      if (st == S_IDLE && nxt == S_ROW) rc <= '0;
      else if (!(&rc))                  rc <= rc + 1'b1;
      if (load) begin
        a_r  <= req_addr;
        we_r <= req_we;
        be_r <= req_be;
        wd_r <= req_wdata;
      end
      done <= fin;
      if (fin && !we_r) rd_data <= dq_in;
    end
  end

  assign ras_n    = !(st inside {S_ROW, S_COLA, S_CAS, S_OPEN});
  assign cas_hi_n = !(strobe && (!we_r || be_r[1]));
  assign cas_lo_n = !(strobe && (!we_r || be_r[0]));
  assign we_n     = !(strobe && we_r);
  assign oe_n     = !(strobe && !we_r);
  assign dq_oe    = strobe && we_r;
  assign dq_out   = wd_r;
  assign mem_addr = (st inside {S_IDLE, S_ROW, S_PRE}) ? a_r[AW-1:MAW] : a_r[MAW-1:0];
endmodule

// File: rtl/dram_page_seq_chk.sv
module dram_page_seq_chk #(
  parameter int RAS_MAX_CYC = 7500,
  parameter int RCD_CYC     = 2,
  parameter int RP_CYC      = 3,
  parameter int MAW         = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ras_n,
  input logic           cas_hi_n,
  input logic           cas_lo_n,
  input logic           we_n,
  input logic           oe_n,
  input logic           dq_oe,
  input logic           done,
  input logic [MAW-1:0] mem_addr
);
  localparam int CW = $clog2(RAS_MAX_CYC + RP_CYC + 2) + 1;
  localparam logic [CW-1:0] MAX_L = CW'(RAS_MAX_CYC);
  localparam logic [CW-1:0] RCD_L = CW'(RCD_CYC);
  localparam logic [CW-1:0] RP_L  = CW'(RP_CYC);

  logic [CW-1:0] lc, hc;
  logic cas_any;
  assign cas_any = !cas_hi_n || !cas_lo_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc <= '0;
      hc <= RP_L;
    end else begin
      lc <= ras_n ? '0 : ((&lc) ? lc : lc + 1'b1);
      hc <= ras_n ? ((&hc) ? hc : hc + 1'b1) : '0;
    end
  end

  AST_RAS_LOW_MAX: assert property (@(posedge clk) disable iff (!rst_n) !ras_n |-> lc < MAX_L) else $error("row open too long"); // R10
  AST_RCD_MIN: assert property (@(posedge clk) disable iff (!rst_n) (cas_any && !$past(cas_any)) |-> lc >= RCD_L) else $error("column strobe too early"); // R3
  AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n) cas_any |-> !ras_n) else $error("column strobe without row"); // R3
  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> hc >= RP_L) else $error("precharge too short"); // R9
  AST_BUS_DIR: assert property (@(posedge clk) disable iff (!rst_n) !(dq_oe && !oe_n)) else $error("bus contention"); // R11
  AST_CAS_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (cas_any && $past(cas_any)) |-> ($stable(mem_addr) && $stable(we_n))) else $error("address moved under strobe"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) else $error("done longer than one cycle"); // R6
endmodule

bind dram_page_seq dram_page_seq_chk #(
  .RAS_MAX_CYC(RMAX_C),
  .RCD_CYC(RCD_C),
  .RP_CYC(RP_C),
  .MAW(MAW)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ras_n(ras_n),
  .cas_hi_n(cas_hi_n),
  .cas_lo_n(cas_lo_n),
  .we_n(we_n),
  .oe_n(oe_n),
  .dq_oe(dq_oe),
  .done(done),
  .mem_addr(mem_addr)
);

// File: tb/sim_dram_page_seq.sv
module sim_dram_page_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, req_we = 1'b0, refresh_pend = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0, dq_in = 16'hBAD0;
  logic [15:0] rd_data, dq_out;
  logic        done, ras_n, cas_hi_n, cas_lo_n, we_n, oe_n, dq_oe;
  logic [8:0]  mem_addr;

  dram_page_seq #(.T_RAS_MAX_NS(400)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .refresh_pend(refresh_pend),
    .rd_data(rd_data), .done(done), .ras_n(ras_n), .cas_hi_n(cas_hi_n),
    .cas_lo_n(cas_lo_n), .we_n(we_n), .oe_n(oe_n), .mem_addr(mem_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] mem [0:255];

  bit p_ras = 1, p_cas = 0, first = 0, ca = 0;
  int hi = 99, lo = 0, sf = 99, casl = 0, n_fall = 0, max_lo = 0;
  int min_hi = 99, min_rc = 99, min_rcd = 99, bad_dir = 0;
  logic [8:0] mrow = '0, mcol = '0;

  function automatic int idx(input logic [8:0] r, input logic [8:0] c);
    return int'({r[2:0], c[4:0]});
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1; p_cas = 0; lo = 0; hi = 99; sf = 99; casl = 0;
    end else begin
      ca = !cas_hi_n || !cas_lo_n;
      sf++;
      if (ras_n) begin
        hi++; lo = 0;
      end else begin
        if (p_ras) begin
          if (hi < min_hi) min_hi = hi;
          if (sf < min_rc) min_rc = sf;
          sf = 0; hi = 0; lo = 0; first = 1;
          mrow = mem_addr; n_fall++;
        end
        lo++;
        if (lo > max_lo) max_lo = lo;
      end
      if (ca && !p_cas) begin
        mcol = mem_addr;
        if (first) begin
          if (lo - 1 < min_rcd) min_rcd = lo - 1;
          first = 0;
        end
        if (!we_n) begin
          if (!dq_oe || !oe_n) bad_dir++;
          if (!cas_hi_n) mem[idx(mrow, mcol)][15:8] = dq_out[15:8];
          if (!cas_lo_n) mem[idx(mrow, mcol)][7:0]  = dq_out[7:0];
        end
        casl = 0; dq_in = 16'hBAD0;
      end else if (ca) begin
        casl++;
        dq_in = (!oe_n && casl >= 1) ? mem[idx(mrow, mcol)] : 16'hBAD0;
      end else begin
        dq_in = 16'hBAD0;
      end
      if (dq_oe && !oe_n) bad_dir++;
      p_ras = ras_n; p_cas = ca;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [17:0] a, input logic [1:0] be,
                     input logic [15:0] d, output logic [15:0] q);
    int n;
    req = 1; req_we = w; req_addr = a; req_be = be; req_wdata = d;
    n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 200);
    if (!done) chk(0, "R6 done never pulsed", 0, 1);
    q = rd_data;
    req = 0;
  endtask

  task automatic close_row();
    refresh_pend = 1;
    repeat (3) @(negedge clk);
    refresh_pend = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk({ras_n, cas_hi_n, cas_lo_n, we_n, oe_n, dq_oe, done} == 7'b1111100, "R1 strobes in reset",
        int'({ras_n, cas_hi_n, cas_lo_n, we_n, oe_n, dq_oe, done}), 7'b1111100);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk({ras_n, cas_hi_n, cas_lo_n, we_n, oe_n, dq_oe, done} == 7'b1111100, "R1 strobes idle",
        int'({ras_n, cas_hi_n, cas_lo_n, we_n, oe_n, dq_oe, done}), 7'b1111100);
  endtask

  task automatic t_addr();
    logic [15:0] q;
    acc(1, {9'h0A3, 9'h015}, 2'b11, 16'h1234, q);
    chk(mrow == 9'h0A3, "R2 row half on bus", int'(mrow), 'h0A3);
    chk(mcol == 9'h015, "R2 column half on bus", int'(mcol), 'h015);
    close_row();
    acc(0, {9'h0A3, 9'h015}, 2'b00, 16'h0000, q);
    chk(q == 16'h1234, "R6 read after write", int'(q), 'h1234);
  endtask

  task automatic t_bytes();
    logic [15:0] q;
    logic [17:0] a = {9'h041, 9'h007};
    close_row();
    acc(1, a, 2'b11, 16'hAAAA, q);
    close_row();
    acc(1, a, 2'b01, 16'h1155, q);
    acc(0, a, 2'b00, 16'h0000, q);
    chk(q == 16'hAA55, "R4 lower lane only", int'(q), 'hAA55);
    acc(1, a, 2'b10, 16'h77EE, q);
    acc(1, a, 2'b00, 16'h0000, q);
    close_row();
    acc(0, a, 2'b00, 16'h0000, q);
    chk(q == 16'h7755, "R4 upper lane only, none unchanged", int'(q), 'h7755);
  endtask

  task automatic t_page();
    logic [15:0] q;
    int n0;
    close_row();
    n0 = n_fall;
    for (int i = 0; i < 3; i++) acc(1, {9'h120, 9'(i + 1)}, 2'b11, 16'hC000 + 16'(i), q);
    for (int i = 0; i < 3; i++) begin
      acc(0, {9'h120, 9'(i + 1)}, 2'b00, 16'h0000, q);
      chk(q == 16'hC000 + 16'(i), "R7 page read data", int'(q), 'hC000 + i);
    end
    chk(n_fall - n0 == 1, "R7 row opened once for burst", n_fall - n0, 1);
  endtask

  task automatic t_miss();
    logic [15:0] q;
    int n0;
    close_row();
    n0 = n_fall;
    acc(1, {9'h033, 9'h002}, 2'b11, 16'h5A5A, q);
    acc(1, {9'h034, 9'h002}, 2'b11, 16'hA5A5, q);
    acc(0, {9'h033, 9'h002}, 2'b00, 16'h0000, q);
    chk(q == 16'h5A5A, "R8 data after row change", int'(q), 'h5A5A);
    chk(n_fall - n0 == 3, "R8 row reopened on each miss", n_fall - n0, 3);
  endtask

  task automatic t_refresh();
    logic [15:0] q;
    int n0;
    acc(0, {9'h034, 9'h002}, 2'b00, 16'h0000, q);
    chk(q == 16'hA5A5, "R8 read second row", int'(q), 'hA5A5);
    refresh_pend = 1;
    repeat (2) @(negedge clk);
    chk(ras_n == 1'b1, "R8 refresh closes idle row", int'(ras_n), 1);
    refresh_pend = 0;
    repeat (6) @(negedge clk);
    n0 = n_fall;
    acc(0, {9'h034, 9'h002}, 2'b00, 16'h0000, q);
    chk(n_fall - n0 == 1 && q == 16'hA5A5, "R8 reopen after refresh", n_fall - n0, 1);
  endtask

  task automatic t_rasmax();
    logic [15:0] q;
    int n0;
    close_row();
    acc(0, {9'h033, 9'h002}, 2'b00, 16'h0000, q);
    repeat (60) @(negedge clk);
    chk(ras_n == 1'b1, "R10 idle row closed by limit", int'(ras_n), 1);
    n0 = n_fall;
    for (int i = 0; i < 14; i++) acc(1, {9'h0C5, 9'(i)}, 2'b11, 16'h3000 + 16'(i), q);
    chk(n_fall - n0 >= 2, "R10 burst row reopened", n_fall - n0, 2);
    acc(0, {9'h0C5, 9'd0}, 2'b00, 16'h0000, q);
    chk(q == 16'h3000, "R10 burst first word", int'(q), 'h3000);
    acc(0, {9'h0C5, 9'd13}, 2'b00, 16'h0000, q);
    chk(q == 16'h300D, "R10 burst last word", int'(q), 'h300D);
    chk(max_lo <= 40, "R10 longest row-open time", max_lo, 40);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    @(negedge clk);
    t_reset();
    t_addr();
    t_bytes();
    t_page();
    t_miss();
    t_refresh();
    t_rasmax();
    chk(min_rcd >= 2, "R3 ras-to-cas cycles", min_rcd, 2);
    chk(min_hi >= 3, "R9 precharge cycles", min_hi, 3);
    chk(min_rc >= 7, "R9 ras cycle length", min_rc, 7);
    chk(bad_dir == 0, "R11 R5 bus direction", bad_dir, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule